// File: doc/BRIEF.md
# Base-Index-Displacement Address Generator

This block turns a 32-bit instruction word into the effective address of its storage operand. It pulls the fields out of the word, counting bit positions from the left. Bits 0 to 7 are the opcode and bits 8 to 11 are the first register field. The block then reads the base register and, where the format has one, the index register through two read ports of a 16-entry register file. The operand value is the sum of those register contents and a 12-bit unsigned displacement.

The opcode places each instruction in one of three groups. An indexed instruction carries an index nibble in bits 12 to 15. A storage instruction uses that nibble as a second register number, so it plays no part in the address. A shift instruction forms the same base-plus-displacement sum, but the sum is a count, not an address. A register number of zero in the base or index field adds zero and never reads register 0. A mode input picks one of two results: a 24-bit address space, or a full 32-bit sum that wraps. The result appears one clock after the instruction is presented, with a valid strobe.

Top module: `bxd_agen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` is 0 after that edge.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high, and 0 otherwise.
- R3: `out_opcode` equals `in_word[31:24]` and `out_r1` equals `in_word[23:20]` of the captured word.
- R4: For an indexed opcode (any opcode not listed in R7 or R9), `out_ea` = reg[`in_word[15:12]`] + reg[`in_word[19:16]`] + zero-extended `in_word[11:0]`. Register contents are unsigned. The block drives `base_sel` = `in_word[15:12]` and `idx_sel` = `in_word[19:16]`.
- R5: A base field of 0 contributes zero, whatever register 0 holds.
- R6: An index field of 0 contributes zero, whatever register 0 holds.
- R7: For storage opcodes 0x90 and 0x98, `in_word[19:16]` is not an index, and the index read value is never added.
- R8: With `mode32` = 0 the address is the low 24 bits of the sum, and bits 31:24 are 0. With `mode32` = 1 the sum wraps modulo 2^32.
- R9: For shift opcodes 0x88 to 0x8F, `out_is_count` is 1 and `out_ea` holds the low 6 bits of base + displacement, with the upper bits 0. For all other opcodes `out_is_count` is 0.
- R10: The displacement is unsigned. The value 0xFFF adds 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word, bit 0 = MSB |
| mode32 | input | 1 | 1: 32-bit wrapping sum, 0: 24-bit address |
| base_sel | output | 4 | Register number for the base read port |
| base_val | input | 32 | Register contents for `base_sel` (same cycle) |
| idx_sel | output | 4 | Register number for the index read port |
| idx_val | input | 32 | Register contents for `idx_sel` (same cycle) |
| out_valid | output | 1 | Result strobe |
| out_opcode | output | 8 | Captured opcode |
| out_r1 | output | 4 | Captured first register field |
| out_ea | output | 32 | Effective address or shift count |
| out_is_count | output | 1 | `out_ea` is a shift count |

## Verification
Each fault in the datapath shows up on `out_ea` one clock after the faulty word is presented. A wrong zero-field mask shows as the extra value planted in register 0. A wrong format class shows as an added index value. A wrong reduction shows as stray bits above bit 23 or above bit 5. A bad capture register or a broken strobe path shows in the same cycle, as a stale opcode or as a valid strobe that is missing or lasts too long. The bench plants distinct values in every register, so a wrongly selected or wrongly masked operand changes the sum in a way that can be traced.

// File: rtl/bxd_pkg.sv
// Package: shared field widths, the format class and the decoded-field
// record for the base-index-displacement address generator.
// Assumes bit 0 of an instruction word is its most significant bit.
package bxd_pkg;
    localparam int WORD_W = 32;
    localparam int OPC_W  = 8;
    localparam int REG_W  = 4;
    localparam int DISP_W = 12;

    typedef enum logic [1:0] {
        FMT_INDEXED = 2'd0,
        FMT_STORAGE = 2'd1,
        FMT_COUNT   = 2'd2
    } fmt_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [REG_W-1:0]  r1;
        logic [REG_W-1:0]  x2;
        logic [REG_W-1:0]  b2;
        logic [DISP_W-1:0] disp;
        fmt_e              fmt;
    } dec_t;

    // Opcode lookup: shifts 0x88..0x8F are counts, 0x90/0x98 are storage.
    function automatic fmt_e classify(input logic [OPC_W-1:0] opc);
        if (opc[7:3] == 5'b10001)
            return FMT_COUNT;
        else if (opc == 8'h90 || opc == 8'h98)
            return FMT_STORAGE;
        else
            return FMT_INDEXED;
    endfunction
endpackage

// File: rtl/bxd_decode.sv
// Module: bxd_decode
// Splits an instruction word into its fields and classifies the opcode.
// Assumes left-to-right bit numbering: opcode, R1, X2/R3, B2, displacement.
module bxd_decode
    import bxd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    localparam int OPC_LSB  = WORD_W - OPC_W;
    localparam int R1_LSB   = OPC_LSB - REG_W;
    localparam int X2_LSB   = R1_LSB - REG_W;
    localparam int B2_LSB   = X2_LSB - REG_W;

    // Field extraction and format lookup.
    always_comb begin
        dec.opc  = word[OPC_LSB +: OPC_W];
        dec.r1   = word[R1_LSB +: REG_W];
        dec.x2   = word[X2_LSB +: REG_W];
        dec.b2   = word[B2_LSB +: REG_W];
        dec.disp = word[DISP_W-1:0];
        dec.fmt  = classify(word[OPC_LSB +: OPC_W]);
    end
endmodule

// File: rtl/bxd_operand.sv
// Module: bxd_operand
// Turns the two register-file reads into addend values. A register number
// of zero yields zero. The index port (slot 1) only counts for indexed formats.
// Assumes the register file answers combinationally in the same cycle.
module bxd_operand
    import bxd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  dec_t              dec,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] idx_val,
    output logic [ADDR_W-1:0] base_term,
    output logic [ADDR_W-1:0] idx_term
);
    localparam int NPORT = 2;

    logic [REG_W-1:0]  sel  [NPORT];
    logic [ADDR_W-1:0] rval [NPORT];
    logic              allow[NPORT];
    logic [ADDR_W-1:0] term [NPORT];

    // Gather per-port inputs into arrays.
    always_comb begin
        sel[0]   = dec.b2;
        sel[1]   = dec.x2;
        rval[0]  = base_val;
        rval[1]  = idx_val;
        allow[0] = 1'b1;
        allow[1] = (dec.fmt == FMT_INDEXED);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Zero the addend for register number 0 or a port the format ignores.
        always_comb begin
            if (sel[p] == '0 || !allow[p])
                term[p] = '0;
            else
                term[p] = rval[p];
        end
    end

    assign base_term = term[0];
    assign idx_term  = term[1];
endmodule

// File: rtl/bxd_sum.sv
// Module: bxd_sum
// Adds base, index and zero-extended displacement, then reduces the result:
// a count keeps its low CNT_W bits, an address keeps NARROW_W bits in narrow
// mode or wraps at ADDR_W bits in wide mode.
module bxd_sum
    import bxd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 24,
    parameter int CNT_W    = 6
) (
    input  logic [ADDR_W-1:0] base_term,
    input  logic [ADDR_W-1:0] idx_term,
    input  logic [DISP_W-1:0] disp,
    input  logic              is_count,
    input  logic              wide,
    output logic [ADDR_W-1:0] result
);
    localparam logic [ADDR_W-1:0] NARROW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [ADDR_W-1:0] CNT_MASK    = {{(ADDR_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [ADDR_W-1:0] raw;

    // Modulo-2^ADDR_W three-term sum.
    always_comb raw = base_term + idx_term + {{(ADDR_W-DISP_W){1'b0}}, disp};

    // Reduction by operand kind and address mode.
    always_comb begin
        if (is_count)
            result = raw & CNT_MASK;
        else if (!wide)
            result = raw & NARROW_MASK;
        else
            result = raw;
    end
endmodule

// File: rtl/bxd_agen.sv
// Module: bxd_agen (top)
// Decodes the storage operand of an instruction word, reads base and index
// registers through two register-file read ports and registers the effective
// address one cycle later. Assumes synchronous active-low reset and a
// register file that answers combinationally.
module bxd_agen
    import bxd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 24,
    parameter int CNT_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              mode32,
    output logic [REG_W-1:0]  base_sel,
    input  logic [ADDR_W-1:0] base_val,
    output logic [REG_W-1:0]  idx_sel,
    input  logic [ADDR_W-1:0] idx_val,
    output logic              out_valid,
    output logic [OPC_W-1:0]  out_opcode,
    output logic [REG_W-1:0]  out_r1,
    output logic [ADDR_W-1:0] out_ea,
    output logic              out_is_count
);
    dec_t              dec;
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] idx_term;
    logic [ADDR_W-1:0] ea_next;
    logic              cnt_next;

    bxd_decode u_dec (
        .word (in_word),
        .dec  (dec)
    );

    assign base_sel = dec.b2;
    assign idx_sel  = dec.x2;
    assign cnt_next = (dec.fmt == FMT_COUNT);

    bxd_operand #(.ADDR_W(ADDR_W)) u_opd (
        .dec       (dec),
        .base_val  (base_val),
        .idx_val   (idx_val),
        .base_term (base_term),
        .idx_term  (idx_term)
    );

    bxd_sum #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) u_sum (
        .base_term (base_term),
        .idx_term  (idx_term),
        .disp      (dec.disp),
        .is_count  (cnt_next),
        .wide      (mode32),
        .result    (ea_next)
    );

    // Valid strobe: one cycle behind the input strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Result capture on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_opcode   <= '0;
            out_r1       <= '0;
            out_ea       <= '0;
            out_is_count <= 1'b0;
        end else if (in_valid) begin
            out_opcode   <= dec.opc;
            out_r1       <= dec.r1;
            out_ea       <= ea_next;
            out_is_count <= cnt_next;
        end
    end
endmodule

// File: rtl/bxd_agen_chk.sv
// Module: bxd_agen_chk
// Port-level timing and reduction properties of bxd_agen, bound to it below.
module bxd_agen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        mode32,
    input logic        out_valid,
    input logic [7:0]  out_opcode,
    input logic [31:0] out_ea,
    input logic        out_is_count
);
    // R2
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    opcode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_opcode == $past(in_word[31:24]));

    // R8
    narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode32) |=> out_ea[31:24] == 8'h00);

    // R9
    count_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_count) |-> out_ea[31:6] == 26'd0);

    // R9
    count_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_is_count == ($past(in_word[31:27]) == 5'b10001));
endmodule

bind bxd_agen bxd_agen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_word      (in_word),
    .mode32       (mode32),
    .out_valid    (out_valid),
    .out_opcode   (out_opcode),
    .out_ea       (out_ea),
    .out_is_count (out_is_count)
);

// File: tb/bxd_agen_test.sv
`timescale 1ns/1ps
module bxd_agen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        mode32 = 1'b1;
    logic [3:0]  base_sel, idx_sel;
    logic [31:0] base_val, idx_val;
    logic        out_valid, out_is_count;
    logic [7:0]  out_opcode;
    logic [3:0]  out_r1;
    logic [31:0] out_ea;
    logic [31:0] regs [16];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign base_val = regs[base_sel];
    assign idx_val  = regs[idx_sel];

    bxd_agen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .mode32(mode32), .base_sel(base_sel), .base_val(base_val),
        .idx_sel(idx_sel), .idx_val(idx_val), .out_valid(out_valid),
        .out_opcode(out_opcode), .out_r1(out_r1), .out_ea(out_ea),
        .out_is_count(out_is_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one word for one cycle; return at the following negedge.
    task automatic issue(input logic [31:0] w, input logic m);
        @(negedge clk);
        in_word = w; mode32 = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_indexed;
        regs[11] = 32'h0012_4000; regs[7] = 32'h0000_0300;
        issue(32'h58A7_B125, 1'b1);
        chk("R2 valid", {31'd0, out_valid}, 32'd1);
        chk("R3 opcode", {24'd0, out_opcode}, 32'h58);
        chk("R3 r1", {28'd0, out_r1}, 32'hA);
        chk("R4 ea", out_ea, 32'h0012_4425);
        chk("R9 not count", {31'd0, out_is_count}, 32'd0);
        @(negedge clk);
        chk("R2 strobe drop", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_zero_fields;
        regs[0] = 32'h5555_0000; regs[12] = 32'h0000_2500;
        issue(32'h5840_C123, 1'b1);
        chk("R6 index zero", out_ea, 32'h0000_2623);
        regs[3] = 32'h0000_1000;
        issue(32'h5833_0045, 1'b1);
        chk("R5 base zero", out_ea, 32'h0000_1045);
        issue(32'h4100_0ABC, 1'b1);
        chk("R5 R6 both zero", out_ea, 32'h0000_0ABC);
    endtask

    task automatic t_storage;
        regs[12] = 32'h0000_2500; regs[7] = 32'h0F00_0000;
        issue(32'h9857_C100, 1'b1);
        chk("R7 storage 98", out_ea, 32'h0000_2600);
        issue(32'h9037_C001, 1'b1);
        chk("R7 storage 90", out_ea, 32'h0000_2501);
    endtask

    task automatic t_count;
        regs[8] = 32'h0000_0047; regs[9] = 32'h0000_0100;
        issue(32'h8940_0001, 1'b1);
        chk("R9 count flag", {31'd0, out_is_count}, 32'd1);
        chk("R9 count disp", out_ea, 32'd1);
        issue(32'h8849_8000, 1'b1);
        chk("R9 count base low bits", out_ea, 32'd7);
    endtask

    task automatic t_modes;
        regs[4] = 32'hFFFF_F000;
        issue(32'h5800_4123, 1'b0);
        chk("R8 narrow", out_ea, 32'h00FF_F123);
        issue(32'h5800_4123, 1'b1);
        chk("R8 wide", out_ea, 32'hFFFF_F123);
        regs[5] = 32'hFFFF_FFFF; regs[6] = 32'h0000_0002;
        issue(32'h5806_5000, 1'b1);
        chk("R8 wrap", out_ea, 32'h0000_0001);
    endtask

    task automatic t_disp_max;
        regs[10] = 32'h0000_1000;
        issue(32'h5800_AFFF, 1'b1);
        chk("R10 disp max", out_ea, 32'h0000_1FFF);
    endtask

    task automatic t_back_to_back;
        regs[3] = 32'h0000_0010;
        @(negedge clk);
        in_word = 32'h5800_3001; in_valid = 1'b1; mode32 = 1'b1;
        @(negedge clk);
        chk("R2 first", out_ea, 32'h0000_0011);
        in_word = 32'h5A00_3002;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 second", out_ea, 32'h0000_0012);
        chk("R3 second opcode", {24'd0, out_opcode}, 32'h5A);
        chk("R2 held valid", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0100_0000 * i + 32'h0000_0777;
        t_reset();
        t_indexed();
        t_zero_fields();
        t_storage();
        t_count();
        t_modes();
        t_disp_max();
        t_back_to_back();
        t_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule